// File: doc/BRIEF.md
# Multi-Mode Fan Duty Controller

This block drives one cooling fan. Every clock it works out a requested 8-bit duty under one of three modes. In manual mode the duty is a value written from outside. In temperature mode a five-step staircase maps the current temperature to a duty. In speed mode a closed loop steps the duty toward a target tachometer count. The requested duty and the mode select are sampled only at the start of each PWM period, so the waveform never changes part-way through a cycle.

The staircase is built from three trip points, each a temperature/duty pair. The block inserts a midpoint between each pair of neighbouring trip points, with both temperature and duty set to the rounded-down average. Below the lowest trip temperature the fan is off. The trip temperature, the tachometer count and the PWM output of one instance all belong to the same physical fan. The PWM period is 256 steps long, and each step lasts 2^sel clock cycles, so the select value halves the frequency at every step from the base rate.

Top module: `fan_ctrl`

## Requirements
- R1: After reset, `duty_o` is 0, `pwm_o` is low and the latched mode is manual.
- R2: Mode encoding on `mode_i`: 1 is manual, 2 is temperature, 3 is speed, and 0 acts as manual. In manual mode, `duty_o` equals `manual_duty_i` from the first period boundary onwards.
- R3: `duty_o` and the latched mode change only at a period boundary. A change on any input between boundaries leaves `duty_o` unchanged until the next boundary.
- R4: In each period, `pwm_o` is high while the 8-bit step count is below `duty_o`, so a period holds duty × 2^sel high cycles. A duty of 0 gives a constant low.
- R5: A period lasts 256 × 2^sel clock cycles, where sel is `freq_sel_i` limited to MAX_SEL. The first boundary after reset comes at the 256 × 2^sel-th rising edge with reset released.
- R6: In temperature mode, a temperature below the lowest trip temperature (bits [7:0] of `trip_temp_i`) gives a duty of 0.
- R7: In temperature mode, the points in order are trip1, mid(trip1,trip2), trip2, mid(trip2,trip3), trip3. Field k of `trip_temp_i` / `trip_duty_i` (bits [8k+7:8k]) holds trip k+1. A midpoint is floor((a+b)/2) for both temperature and duty. The duty is that of the highest point whose temperature is at or below the current temperature.
- R8: In speed mode, each `tach_update_i` pulse raises the loop duty by 1 when `meas_count_i` > `target_count_i` and lowers it by 1 when `meas_count_i` < `target_count_i`. It leaves the duty unchanged when the two counts are equal.
- R9: The speed-mode duty saturates at 255 when stepping up and at 0 when stepping down.
- R10: On entry to speed mode, regulation starts from the duty that was applied just before the switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Mode select, sampled at period boundaries |
| manual_duty_i | input | 8 | Duty used in manual mode |
| trip_temp_i | input | 24 | Three trip temperatures, lowest in bits [7:0] |
| trip_duty_i | input | 24 | Duties for the three trip points, same layout |
| temp_i | input | 8 | Current temperature of this fan's sensor |
| target_count_i | input | 12 | Target tachometer count (larger means slower) |
| meas_count_i | input | 12 | Latest measured tachometer count |
| tach_update_i | input | 1 | One-cycle pulse when a new measurement is valid |
| freq_sel_i | input | 4 | PWM divider exponent; values above MAX_SEL are limited to MAX_SEL |
| duty_o | output | 8 | Duty applied in the current period |
| pwm_o | output | 1 | PWM waveform |

## Verification
The temperature mode is driven at the lowest trip point, one degree below it, at each midpoint, between points and far above the top point. These values separate an off-by-one in the comparison, a wrong midpoint and a missing floor at zero. The speed loop is driven with counts above, below and equal to the target, and is pushed into both rails. This separates the direction of the step, the dead zone and saturation. Mid-period changes to duty and to mode show whether sampling waits for the boundary. High-cycle counts under two divider settings tie the waveform to the duty and to the period length.

// File: rtl/fanctl_pkg.sv
package fanctl_pkg;
  typedef enum logic [1:0] {
    FM_RSVD   = 2'd0,
    FM_MANUAL = 2'd1,
    FM_TEMP   = 2'd2,
    FM_SPEED  = 2'd3
  } fan_mode_e;
endpackage

// File: rtl/fan_stair_map.sv
module fan_stair_map #(
  parameter int TW = 8,
  parameter int DW = 8,
  parameter int NTRIP = 3
) (
  input  logic [TW-1:0]       temp,
  input  logic [NTRIP*TW-1:0] trip_t,
  input  logic [NTRIP*DW-1:0] trip_d,
  output logic [DW-1:0]       duty
);
  localparam int NPT = 2 * NTRIP - 1;

  function automatic logic [TW-1:0] mid_t(input logic [TW-1:0] a, input logic [TW-1:0] b);
    logic [TW:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[TW:1];
  endfunction

  function automatic logic [DW-1:0] mid_d(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic [DW:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[DW:1];
  endfunction

  logic [TW-1:0] pt_t [NPT];
  logic [DW-1:0] pt_d [NPT];

  for (genvar k = 0; k < NTRIP; k++) begin : g_trip
    assign pt_t[2*k] = trip_t[k*TW +: TW];
    assign pt_d[2*k] = trip_d[k*DW +: DW];
  end
  for (genvar k = 0; k < NTRIP - 1; k++) begin : g_mid
    assign pt_t[2*k+1] = mid_t(trip_t[k*TW +: TW], trip_t[(k+1)*TW +: TW]);
    assign pt_d[2*k+1] = mid_d(trip_d[k*DW +: DW], trip_d[(k+1)*DW +: DW]);
  end

  always_comb begin
    duty = '0;
    for (int i = 0; i < NPT; i++) begin
      if (temp >= pt_t[i]) duty = pt_d[i];
    end
  end
endmodule

// File: rtl/fan_speed_loop.sv
module fan_speed_loop #(
  parameter int DW = 8,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          regulate,
  input  logic          tach_upd,
  input  logic [CW-1:0] meas,
  input  logic [CW-1:0] target,
  input  logic [DW-1:0] track_duty,
  output logic [DW-1:0] duty
);
  localparam logic [DW-1:0] DMAX = '1;

  logic step_up, step_dn;
  assign step_up = regulate && tach_upd && (meas > target) && (duty != DMAX);
  assign step_dn = regulate && tach_upd && (meas < target) && (duty != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)        duty <= '0;
    else if (!regulate) duty <= track_duty;
    else if (step_up)  duty <= duty + 1'b1;
    else if (step_dn)  duty <= duty - 1'b1;
  end

  // R8: a tach update moves the duty by at most one LSB
  a_r8_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    $past(regulate) && regulate |-> (duty == $past(duty)) ||
      (duty == $past(duty) + 1'b1) || (duty == $past(duty) - 1'b1));
  // R9: ceiling holds
  a_r9_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    regulate && tach_upd && duty == DMAX && meas > target |=> duty == DMAX);
  // R9: floor holds
  a_r9_floor: assert property (@(posedge clk) disable iff (!rst_n)
    regulate && tach_upd && duty == '0 && meas < target |=> duty == '0);
endmodule

// File: rtl/fan_pwm_gen.sv
module fan_pwm_gen #(
  parameter int DW = 8,
  parameter int SEL_W = 4,
  parameter int MAX_SEL = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic [DW-1:0]    duty_req,
  output logic [DW-1:0]    duty_q,
  output logic             pwm,
  output logic             wrap
);
  localparam int PRE_W = (MAX_SEL > 0) ? MAX_SEL : 1;

  logic [SEL_W-1:0] sel_c;
  logic [PRE_W:0]   one_sh;
  logic [PRE_W-1:0] term, pre;
  logic [DW-1:0]    pcnt;
  logic             tick;

  assign sel_c  = (sel > SEL_W'(MAX_SEL)) ? SEL_W'(MAX_SEL) : sel;
  assign one_sh = (PRE_W+1)'(1) << sel_c;
  assign term   = PRE_W'(one_sh - 1'b1);
  assign tick   = (pre >= term);
  assign wrap   = tick && (pcnt == '1);
  assign pwm    = (pcnt < duty_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre    <= '0;
      pcnt   <= '0;
      duty_q <= '0;
    end else begin
      pre <= tick ? '0 : pre + 1'b1;
      if (tick) pcnt <= pcnt + 1'b1;
      if (wrap) duty_q <= duty_req;
    end
  end

  // R3: applied duty only moves at a boundary
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(duty_q));
  // R4: a non-zero duty starts the period high
  a_r4_start_high: assert property (@(posedge clk) disable iff (!rst_n)
    wrap && duty_req != '0 |=> pwm);
endmodule

// File: rtl/fan_ctrl.sv
module fan_ctrl
  import fanctl_pkg::*;
#(
  parameter int DW = 8,
  parameter int TW = 8,
  parameter int CW = 12,
  parameter int SEL_W = 4,
  parameter int MAX_SEL = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic [DW-1:0]    manual_duty_i,
  input  logic [3*TW-1:0]  trip_temp_i,
  input  logic [3*DW-1:0]  trip_duty_i,
  input  logic [TW-1:0]    temp_i,
  input  logic [CW-1:0]    target_count_i,
  input  logic [CW-1:0]    meas_count_i,
  input  logic             tach_update_i,
  input  logic [SEL_W-1:0] freq_sel_i,
  output logic [DW-1:0]    duty_o,
  output logic             pwm_o
);
  fan_mode_e     active_mode;
  logic [DW-1:0] stair_duty, loop_duty, duty_req;
  logic          wrap;
  logic          regulate;

  assign regulate = (active_mode == FM_SPEED);

  fan_stair_map #(.TW(TW), .DW(DW), .NTRIP(3)) u_stair (
    .temp(temp_i), .trip_t(trip_temp_i), .trip_d(trip_duty_i), .duty(stair_duty));

  fan_speed_loop #(.DW(DW), .CW(CW)) u_loop (
    .clk(clk), .rst_n(rst_n), .regulate(regulate), .tach_upd(tach_update_i),
    .meas(meas_count_i), .target(target_count_i), .track_duty(duty_o), .duty(loop_duty));

  always_comb begin
    case (fan_mode_e'(mode_i))
      FM_TEMP:  duty_req = stair_duty;
      FM_SPEED: duty_req = loop_duty;
      default:  duty_req = manual_duty_i;
    endcase
  end

  fan_pwm_gen #(.DW(DW), .SEL_W(SEL_W), .MAX_SEL(MAX_SEL)) u_pwm (
    .clk(clk), .rst_n(rst_n), .sel(freq_sel_i), .duty_req(duty_req),
    .duty_q(duty_o), .pwm(pwm_o), .wrap(wrap));

  always_ff @(posedge clk) begin
    if (!rst_n)    active_mode <= FM_MANUAL;
    else if (wrap) active_mode <= fan_mode_e'(mode_i);
  end

  // R6: temperature below the lowest trip point turns the fan off
  a_r6_off_below: assert property (@(posedge clk) disable iff (!rst_n)
    wrap && mode_i == 2'd2 && temp_i < trip_temp_i[TW-1:0] |=> duty_o == '0);
  // R10: entering speed mode keeps the applied duty
  a_r10_seamless: assert property (@(posedge clk) disable iff (!rst_n)
    wrap && mode_i == 2'd3 && active_mode != FM_SPEED |=> $stable(duty_o));
  // R3: latched mode only changes at a boundary
  a_r3_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(active_mode));
endmodule

// File: tb/fan_ctrl_tb.sv
module fan_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'd1;
  logic [7:0]  mdu = 8'd0;
  logic [23:0] ttemp = {8'd81, 8'd60, 8'd40};
  logic [23:0] tduty = {8'd201, 8'd120, 8'd80};
  logic [7:0]  temp = 8'd0;
  logic [11:0] tgt = 12'd200;
  logic [11:0] meas = 12'd200;
  logic        tach = 1'b0;
  logic [3:0]  fsel = 4'd0;
  logic [7:0]  duty_o;
  logic        pwm_o;

  int cyc = 0;
  int per = 256;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fan_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .manual_duty_i(mdu),
    .trip_temp_i(ttemp), .trip_duty_i(tduty), .temp_i(temp),
    .target_count_i(tgt), .meas_count_i(meas), .tach_update_i(tach),
    .freq_sel_i(fsel), .duty_o(duty_o), .pwm_o(pwm_o));

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic do_reset(input logic [3:0] s);
    rst_n = 1'b0;
    fsel = s;
    per = 256 << s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic to_boundary();
    do @(negedge clk); while (cyc % per != 0);
  endtask

  task automatic count_high(output int h);
    h = 0;
    for (int i = 0; i < per; i++) begin
      h += int'(pwm_o);
      @(negedge clk);
    end
  endtask

  task automatic tach_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tach = 1'b1;
      @(negedge clk); tach = 1'b0;
    end
  endtask

  // Own staircase model: list the five points and pick the last one not above temp
  function automatic int stair_ref(input int t);
    int pt[5], pd[5], r;
    pt[0] = 40; pd[0] = 80;  pt[2] = 60; pd[2] = 120; pt[4] = 81; pd[4] = 201;
    pt[1] = (pt[0] + pt[2]) / 2; pd[1] = (pd[0] + pd[2]) / 2;
    pt[3] = (pt[2] + pt[4]) / 2; pd[3] = (pd[2] + pd[4]) / 2;
    r = 0;
    for (int i = 0; i < 5; i++) if (t >= pt[i]) r = pd[i];
    return r;
  endfunction

  task automatic t_reset();
    do_reset(4'd0);
    @(negedge clk);
    chk("R1 duty after reset", duty_o, 0);
    chk("R1 pwm after reset", pwm_o, 0);
  endtask

  task automatic t_manual();
    int h;
    mode = 2'd1; mdu = 8'd100;
    to_boundary();
    chk("R2 manual duty", duty_o, 100);
    count_high(h);
    chk("R4 high cycles per period", h, 100);
    mode = 2'd0; mdu = 8'd37;
    to_boundary();
    chk("R2 mode 0 acts as manual", duty_o, 37);
    mode = 2'd1; mdu = 8'd0;
    to_boundary();
    count_high(h);
    chk("R4 zero duty stays low", h, 0);
  endtask

  task automatic t_defer();
    mode = 2'd1; mdu = 8'd100;
    to_boundary();
    repeat (10) @(negedge clk);
    mdu = 8'd30;
    @(negedge clk);
    chk("R3 duty held mid-period", duty_o, 100);
    to_boundary();
    chk("R3 duty taken at boundary", duty_o, 30);
    repeat (20) @(negedge clk);
    mode = 2'd2; temp = 8'd200;
    repeat (5) @(negedge clk);
    chk("R3 mode change held mid-period", duty_o, 30);
    to_boundary();
    chk("R3 mode change at boundary", duty_o, 201);
  endtask

  task automatic t_temp();
    int tv[10] = '{39, 0, 40, 49, 50, 59, 60, 70, 80, 81};
    mode = 2'd2;
    foreach (tv[i]) begin
      temp = 8'(tv[i]);
      to_boundary();
      if (tv[i] < 40) chk("R6 below first trip", duty_o, 0);
      else            chk("R7 staircase", duty_o, stair_ref(tv[i]));
    end
    temp = 8'd255;
    to_boundary();
    chk("R7 above top trip", duty_o, 201);
  endtask

  task automatic t_speed();
    mode = 2'd1; mdu = 8'd100;
    to_boundary();
    to_boundary();
    mode = 2'd3;
    to_boundary();
    chk("R10 speed entry keeps duty", duty_o, 100);
    meas = 12'd300; tach_pulses(5);
    to_boundary();
    chk("R8 step up when slow", duty_o, 105);
    meas = 12'd150; tach_pulses(3);
    to_boundary();
    chk("R8 step down when fast", duty_o, 102);
    meas = 12'd200; tach_pulses(4);
    to_boundary();
    chk("R8 no step at target", duty_o, 102);
    mode = 2'd1; mdu = 8'd254;
    to_boundary();
    mode = 2'd3;
    to_boundary();
    meas = 12'd300; tach_pulses(5);
    to_boundary();
    chk("R9 ceiling 255", duty_o, 255);
    mode = 2'd1; mdu = 8'd1;
    to_boundary();
    mode = 2'd3;
    to_boundary();
    meas = 12'd100; tach_pulses(4);
    to_boundary();
    chk("R9 floor 0", duty_o, 0);
    meas = 12'd200;
  endtask

  task automatic t_divider();
    int h;
    mode = 2'd1; mdu = 8'd64;
    do_reset(4'd2);
    while (cyc < 257) @(negedge clk);
    chk("R5 no boundary at 256 with sel 2", duty_o, 0);
    to_boundary();
    chk("R5 boundary at 1024 with sel 2", duty_o, 64);
    count_high(h);
    chk("R4 R5 high cycles with sel 2", h, 256);
  endtask

  initial begin
    t_reset();
    t_manual();
    t_defer();
    t_temp();
    t_speed();
    t_divider();
    finish_run();
  end

  initial begin
    #1500000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule